// File: doc/BRIEF.md
# Integer Register File with Hardwired Zero Entry

This block is the general-purpose integer register file of a 32-bit load-store processor core. It holds thirty-two 32-bit registers selected by a 5-bit index. Two operand indices are looked up combinationally on every cycle. The first is always a read-only source. The second serves as a source when the operation reads it. A single write port stores a result on the rising clock edge when its enable is high. Index zero is special: it always reads as zero, and any write aimed at it is dropped.

Beside the main array sits a separate pair of 32-bit result registers for the multiply/divide unit, called HI and LO here. One strobe loads both from two inputs at once. Their outputs can be read at any time.

All ports are plain single-cycle control and data pins. The block never stalls, so it needs no valid/ready handshake and applies no back-pressure. A write offered with its enable high is always taken on that edge. A synchronous active-high reset clears every register, HI and LO included.

Top module: `gpr_file`

## Requirements
- R1: After a clock edge with `rst` high, every general register reads zero on both read ports, and `hi_q` and `lo_q` are zero.
- R2: On a rising edge with `wr_en` high and `wr_idx` nonzero, `wr_data` is stored in register `wr_idx`. From the next cycle it reads back on either read port.
- R3: On an edge with `wr_en` low, no general register changes, whatever `wr_idx` and `wr_data` carry.
- R4: A read port whose index is 0 returns zero in every cycle.
- R5: A write with `wr_idx` equal to 0 has no effect. Register 0 still reads zero afterwards, including in the same cycle as the write.
- R6: When `wr_en` is high, `rst` is low and a read index equals a nonzero `wr_idx`, that port returns `wr_data` in the same cycle (write-first bypass).
- R7: The two read ports are independent. Each returns the register named by its own index, even when both indices are equal or differ.
- R8: On an edge with `hilo_we` high, `hi_in` and `lo_in` are loaded together. They appear on `hi_q` and `lo_q` from the next cycle; there is no same-cycle bypass.
- R9: With `hilo_we` low, HI and LO hold their values, and writes to the general registers leave them untouched. Strobing HI/LO does not alter any general register.
- R10: Reset has priority over both write ports. A write offered during reset is lost, and the read ports give no bypass while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rs_idx | input | 5 | Index of the read-only source operand |
| rs_data | output | 32 | Value of register `rs_idx` |
| rt_idx | input | 5 | Index of the second operand |
| rt_data | output | 32 | Value of register `rt_idx` |
| wr_en | input | 1 | Write enable for the general registers |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Data to store |
| hilo_we | input | 1 | Joint load strobe for HI and LO |
| hi_in | input | 32 | New HI value |
| lo_in | input | 32 | New LO value |
| hi_q | output | 32 | Current HI value |
| lo_q | output | 32 | Current LO value |

## Verification
The bench builds the block with its default parameters: thirty-two entries of 32 bits. These defaults make every index reachable, from the hardwired entry 0 to the top entry 31, on both read ports and the write port. Data patterns fill all 32 bits, including all-ones, so a stuck or truncated bit is visible in any entry. The bench compares both read ports and HI/LO against a behavioural model on every clock. This comparison covers bypass cycles, writes aimed at entry 0, and a reset that arrives while both write strobes are high.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  parameter int GPR_ENTRIES = 32;
  parameter int GPR_WIDTH   = 32;

  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int N  = gpr_pkg::GPR_ENTRIES,
  parameter int W  = gpr_pkg::GPR_WIDTH,
  localparam int AW = gpr_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q [N]
);
  for (genvar i = 0; i < N; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign q[i] = '0;
    end else begin : g_reg
      logic hit;
      assign hit = we && (widx == AW'(i));
      always_ff @(posedge clk) begin
        if (rst)      q[i] <= '0;
        else if (hit) q[i] <= wdata;
      end

      p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (we && widx == AW'(i)) |=> (q[i] == $past(wdata)));
      p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !(we && widx == AW'(i)) |=> $stable(q[i]));
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int N  = gpr_pkg::GPR_ENTRIES,
  parameter int W  = gpr_pkg::GPR_WIDTH,
  localparam int AW = gpr_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ridx,
  input  logic [W-1:0]  q [N],
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic          fwd;
  logic [W-1:0]  stored;

  always_comb begin
    stored = '0;
    if (int'(ridx) < N) stored = q[ridx];
  end

  assign fwd   = !rst && we && (widx == ridx) && (ridx != '0);
  assign rdata = fwd ? wdata : stored;

  p_zero_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ridx == '0) |-> (rdata == '0));
  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (we && widx == ridx && ridx != '0) |-> (rdata == wdata));
endmodule

// File: rtl/gpr_hilo.sv
module gpr_hilo #(
  parameter int W = gpr_pkg::GPR_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (load) begin
      hi <= hi_d;
      lo <= lo_d;
    end
  end

  p_hilo_joint_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (hi == $past(hi_d) && lo == $past(lo_d)));
  p_hilo_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(hi) && $stable(lo)));
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int N  = gpr_pkg::GPR_ENTRIES,
  parameter int W  = gpr_pkg::GPR_WIDTH,
  localparam int AW = gpr_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rs_idx,
  output logic [W-1:0]  rs_data,
  input  logic [AW-1:0] rt_idx,
  output logic [W-1:0]  rt_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          hilo_we,
  input  logic [W-1:0]  hi_in,
  input  logic [W-1:0]  lo_in,
  output logic [W-1:0]  hi_q,
  output logic [W-1:0]  lo_q
);
  localparam int NPORTS = 2;

  logic [W-1:0]  q [N];
  logic [AW-1:0] ridx  [NPORTS];
  logic [W-1:0]  rdata [NPORTS];

  assign ridx[0] = rs_idx;
  assign ridx[1] = rt_idx;
  assign rs_data = rdata[0];
  assign rt_data = rdata[1];

  gpr_array #(.N(N), .W(W)) u_array (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wr_data), .q(q)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    gpr_read_port #(.N(N), .W(W)) u_port (
      .clk(clk), .rst(rst), .ridx(ridx[p]), .q(q),
      .we(wr_en), .widx(wr_idx), .wdata(wr_data), .rdata(rdata[p])
    );
  end

  gpr_hilo #(.W(W)) u_hilo (
    .clk(clk), .rst(rst), .load(hilo_we), .hi_d(hi_in), .lo_d(lo_in),
    .hi(hi_q), .lo(lo_q)
  );

  p_reset_clears_hilo_r1: assert property (@(posedge clk)
    $past(rst) |-> (hi_q == '0 && lo_q == '0));
  p_reset_wins_r10: assert property (@(posedge clk)
    (rst && wr_en) |=> (rs_data == '0 || $past(rs_idx) != rs_idx || rs_idx == '0
                        || rst || wr_en));
endmodule

// File: tb/tb_gpr_file.sv
module tb_gpr_file;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rs_idx, rt_idx, wr_idx;
  logic [31:0] rs_data, rt_data, wr_data, hi_in, lo_in, hi_q, lo_q;
  logic        wr_en, hilo_we;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  logic [31:0] m [32];
  logic [31:0] m_hi, m_lo;

  always #5 clk = ~clk;

  gpr_file dut (
    .clk(clk), .rst(rst), .rs_idx(rs_idx), .rs_data(rs_data),
    .rt_idx(rt_idx), .rt_data(rt_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .hilo_we(hilo_we), .hi_in(hi_in), .lo_in(lo_in),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  function automatic logic [31:0] exp_read(input logic [4:0] idx);
    if (idx == 0) return 32'h0;
    if (!rst && wr_en && wr_idx == idx) return wr_data;
    return m[idx];
  endfunction

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    cmp("rs_data", rs_data, exp_read(rs_idx));
    cmp("rt_data", rt_data, exp_read(rt_idx));
    cmp("hi_q", hi_q, m_hi);
    cmp("lo_q", lo_q, m_lo);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 32; i++) m[i] = 32'h0;
      m_hi = 32'h0;
      m_lo = 32'h0;
    end else begin
      if (wr_en && wr_idx != 0) m[wr_idx] = wr_data;
      if (hilo_we) begin
        m_hi = hi_in;
        m_lo = lo_in;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; hilo_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 32'hx;
    m_hi = 32'hx; m_lo = 32'hx;
    rst = 1; rs_idx = 0; rt_idx = 0; wr_idx = 0; wr_data = 0;
    wr_en = 0; hilo_we = 0; hi_in = 0; lo_in = 0;
    @(negedge clk);
    @(posedge clk);
    for (int i = 0; i < 32; i++) m[i] = 32'h0;
    m_hi = 0; m_lo = 0;
    @(negedge clk);

    // R1: reset state on every index
    cur_req = "R1";
    rst = 0;
    for (int i = 0; i < 32; i += 2) begin
      rs_idx = 5'(i); rt_idx = 5'(i + 1); tick();
    end

    // R2: fill every nonzero register, read back next cycle
    cur_req = "R2";
    for (int i = 1; i < 32; i++) begin
      wr_en = 1; wr_idx = 5'(i); wr_data = 32'(i) * 32'h9E3779B9;
      rs_idx = 5'(i - 1); rt_idx = 5'((i + 7) % 32);
      tick();
    end
    idle();
    wr_idx = 31; wr_data = 32'hFFFF_FFFF; wr_en = 1; tick();
    idle(); rs_idx = 31; rt_idx = 30; tick();

    // R3: enable low, junk on write pins
    cur_req = "R3";
    for (int i = 1; i < 32; i++) begin
      wr_en = 0; wr_idx = 5'(i); wr_data = 32'hDEAD_0000 | 32'(i);
      rs_idx = 5'(i); rt_idx = 5'(32 - i);
      tick();
    end

    // R4/R5: writes to entry 0 dropped, no bypass there
    cur_req = "R5";
    wr_en = 1; wr_idx = 0; wr_data = 32'h1234_5678; rs_idx = 0; rt_idx = 0; tick();
    cur_req = "R4";
    idle(); rs_idx = 0; rt_idx = 0; tick();

    // R6: same-cycle bypass on both ports
    cur_req = "R6";
    for (int i = 1; i < 32; i += 3) begin
      wr_en = 1; wr_idx = 5'(i); wr_data = ~(32'(i) << 4);
      rs_idx = 5'(i); rt_idx = 5'(i); tick();
      wr_en = 1; wr_idx = 5'(i); wr_data = 32'(i) ^ 32'hA5A5_A5A5;
      rs_idx = 5'(i); rt_idx = 5'((i + 1) % 32); tick();
    end

    // R7: independent ports, equal and different indices
    cur_req = "R7";
    idle();
    for (int i = 0; i < 32; i++) begin
      rs_idx = 5'(i); rt_idx = 5'(31 - i); tick();
      rt_idx = 5'(i); tick();
    end

    // R8: joint HI/LO load, visible next cycle
    cur_req = "R8";
    hilo_we = 1; hi_in = 32'hCAFE_0001; lo_in = 32'h0BAD_F00D; tick();
    hilo_we = 0; hi_in = 32'h1; lo_in = 32'h2; tick();
    hilo_we = 1; hi_in = 32'hFFFF_FFFF; lo_in = 32'h0; tick();

    // R9: HI/LO hold during GPR writes; GPRs hold during HI/LO load
    cur_req = "R9";
    hilo_we = 0;
    for (int i = 1; i < 8; i++) begin
      wr_en = 1; wr_idx = 5'(i); wr_data = 32'h5555_0000 + 32'(i);
      hi_in = 32'(i); lo_in = ~32'(i); rs_idx = 5'(i); rt_idx = 5'(i + 1); tick();
    end
    wr_en = 0; hilo_we = 1; hi_in = 32'h7777_7777; lo_in = 32'h8888_8888;
    rs_idx = 3; rt_idx = 4; tick();
    hilo_we = 0; tick();

    // R10: reset wins over both writes, no bypass during reset
    cur_req = "R10";
    rst = 1; wr_en = 1; wr_idx = 9; wr_data = 32'hBEEF_BEEF;
    hilo_we = 1; hi_in = 32'h3; lo_in = 32'h4; rs_idx = 9; rt_idx = 9; tick();
    rst = 0; idle();
    cur_req = "R1";
    for (int i = 0; i < 32; i += 2) begin
      rs_idx = 5'(i); rt_idx = 5'(i + 1); tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule